// File: doc/BRIEF.md
# Bit Field Extract Unit

This unit takes one source operand and a 16-bit control word, pulls out a contiguous run of bits, and returns that run shifted down to bit 0 with zeros above it. The control word holds two unsigned bytes: the starting bit index and the field length in bits. A mode input picks whether the operand is 32 or 64 bits wide. The same shifter and mask serve both widths. In the narrow mode the upper half of the source is forced to zero before extraction.

A request is qualified by `req_valid`. The result, a zero flag and a cleared carry flag are registered. They appear together with `res_valid` one clock after the request. Every accepted request rewrites both flags. A field that starts past the operand width, or has zero length, yields zero. A field that runs off the top of the operand keeps only the bits that exist.

A two-state machine tracks whether the output holds a fresh result. In ST_IDLE no fresh result is present; it goes to ST_RESULT on a cycle with `req_valid` high and otherwise stays in ST_IDLE. In ST_RESULT a fresh result is presented; it stays in ST_RESULT on another request (back-to-back) and goes back to ST_IDLE on a cycle without one. Reset places the machine in ST_IDLE.

Top module: `field_extract_unit`

## Requirements
- R1: The control word `req_ctrl` holds the field length in bits 15:8 and the starting bit index in bits 7:0, each an unsigned value from 0 to 255.
- R2: For a field lying wholly inside the operand, `res_data` equals operand bits [start+len-1 : start] placed at bit 0, with all higher bits zero.
- R3: A length of zero gives a result of zero, whatever the start index and source.
- R4: A start index greater than or equal to the operand width (64 when `req_wide`=1, 32 when `req_wide`=0) gives a result of zero.
- R5: When start plus length exceeds the operand width, only the bits from start up to the top of the operand are returned and all bits above them are zero; lengths up to 255 are accepted.
- R6: With `req_wide`=0 only source bits 31:0 take part, and `res_data` bits 63:32 are zero.
- R7: For every result, `res_zero` is 1 exactly when `res_data` is zero, and `res_carry` is 0.
- R8: `res_valid` is 1 in the cycle after a cycle with `req_valid`=1 and 0 in the cycle after a cycle with `req_valid`=0; results for back-to-back requests appear on consecutive cycles.
- R9: When `req_valid` is 0, `res_data`, `res_zero` and `res_carry` keep their values whatever the other inputs do.
- R10: After reset `res_valid` is 0, `res_data` is 0, `res_zero` is 1 and `res_carry` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request qualifier |
| req_src | input | 64 | Source operand |
| req_ctrl | input | 16 | Length in 15:8, start index in 7:0 |
| req_wide | input | 1 | 1 selects 64-bit operand, 0 selects 32-bit |
| res_valid | output | 1 | Result presented this cycle belongs to last cycle's request |
| res_data | output | 64 | Extracted field, right-aligned, zero-extended |
| res_zero | output | 1 | Set when the result is zero |
| res_carry | output | 1 | Carry flag, always cleared by an operation |

## Verification
A wrong state bit shows on `res_valid` in the very next cycle: it stays high after an idle cycle or stays low after a request. A fault in the shifter stages, the mask or the range decode shows in `res_data` one cycle after the offending request, but only for controls that reach the faulty stage or boundary. For that reason the stimulus covers start indices of 0, 31, 32, 63, 64 and 255, and lengths of 0, 1, the operand width and 255. A flag register that fails to load shows as a `res_zero` that disagrees with `res_data` on the same cycle.

// File: rtl/fx_pkg.sv
package fx_pkg;

    // Default geometry of the extract datapath
    localparam int FX_DATA_W   = 64;
    localparam int FX_NARROW_W = 32;
    localparam int FX_FIELD_W  = 8;
    localparam int FX_CTRL_W   = 2 * FX_FIELD_W;

    // Output-side state: does the result register hold a fresh answer
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fx_state_e;

endpackage

// File: rtl/fx_decode.sv
module fx_decode #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int FIELD_W  = 8,
    parameter int CTRL_W   = 16,
    parameter int SHIFT_W  = 6
) (
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic               wide,
    output logic [SHIFT_W-1:0] shift_amt,
    output logic [FIELD_W-1:0] field_len,
    output logic               kill
);
    localparam int CMP_W = FIELD_W + 1;

    logic [FIELD_W-1:0] start_idx;
    logic [CMP_W-1:0]   op_width;
    logic               in_range;

    // Length byte sits above the start byte (R1)
    assign field_len = ctrl[2*FIELD_W-1:FIELD_W];
    assign start_idx = ctrl[FIELD_W-1:0];

    assign op_width  = wide ? CMP_W'(DATA_W) : CMP_W'(NARROW_W);
    assign in_range  = ({1'b0, start_idx} < op_width);

    // Only the low bits steer the shifter; out-of-range starts are killed
    assign shift_amt = start_idx[SHIFT_W-1:0];
    assign kill      = !in_range || (field_len == '0);

endmodule

// File: rtl/fx_gate.sv
module fx_gate #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic              wide,
    output logic [DATA_W-1:0] operand
);
    // Narrow mode clears the upper half so over-run bits read as zero (R5, R6)
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_lo
            assign operand[i] = src[i];
        end else begin : g_hi
            assign operand[i] = src[i] & wide;
        end
    end

endmodule

// File: rtl/fx_shift.sv
module fx_shift #(
    parameter int DATA_W  = 64,
    parameter int SHIFT_W = 6
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHIFT_W-1:0] amt,
    output logic [DATA_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [SHIFT_W+1];

    assign stage[0] = din;

    // Logarithmic right shifter, one stage per amount bit
    for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
        assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign dout = stage[SHIFT_W];

endmodule

// File: rtl/fx_mask.sv
module fx_mask #(
    parameter int DATA_W  = 64,
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] field_len,
    output logic [DATA_W-1:0]  mask
);
    // Bit i survives when it lies below the requested length
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
        assign mask[i] = (field_len > IDX);
    end

endmodule

// File: rtl/field_extract_unit.sv
module field_extract_unit
    import fx_pkg::*;
#(
    parameter int DATA_W   = FX_DATA_W,
    parameter int NARROW_W = FX_NARROW_W,
    parameter int FIELD_W  = FX_FIELD_W,
    parameter int CTRL_W   = FX_CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_src,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic              req_wide,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_zero,
    output logic              res_carry
);
    localparam int SHIFT_W = $clog2(DATA_W);

    fx_state_e          state, next_state;
    logic [SHIFT_W-1:0] shift_amt;
    logic [FIELD_W-1:0] field_len;
    logic               kill;
    logic [DATA_W-1:0]  operand;
    logic [DATA_W-1:0]  shifted;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  field;

    fx_decode #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .FIELD_W  (FIELD_W),
        .CTRL_W   (CTRL_W),
        .SHIFT_W  (SHIFT_W)
    ) u_decode (
        .ctrl      (req_ctrl),
        .wide      (req_wide),
        .shift_amt (shift_amt),
        .field_len (field_len),
        .kill      (kill)
    );

    fx_gate #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_gate (
        .src     (req_src),
        .wide    (req_wide),
        .operand (operand)
    );

    fx_shift #(
        .DATA_W  (DATA_W),
        .SHIFT_W (SHIFT_W)
    ) u_shift (
        .din  (operand),
        .amt  (shift_amt),
        .dout (shifted)
    );

    fx_mask #(
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W)
    ) u_mask (
        .field_len (field_len),
        .mask      (mask)
    );

    // Zero length or out-of-range start forces a zero result (R3, R4)
    assign field = kill ? '0 : (shifted & mask);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   next_state = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: next_state = req_valid ? ST_RESULT : ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // Output registers: loaded only by an accepted request (R7, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_zero  <= 1'b1;
            res_carry <= 1'b0;
        end else if (req_valid) begin
            res_data  <= field;
            res_zero  <= (field == '0);
            res_carry <= 1'b0;
        end
    end

    assign res_valid = (state == ST_RESULT);

endmodule

// File: rtl/fx_checker.sv
module fx_checker #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int FIELD_W  = 8,
    parameter int CTRL_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CTRL_W-1:0] req_ctrl,
    input logic              req_wide,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_zero,
    input logic              res_carry
);
    logic [FIELD_W-1:0] c_len;
    logic [FIELD_W-1:0] c_start;
    int                 c_width;

    assign c_len   = req_ctrl[2*FIELD_W-1:FIELD_W];
    assign c_start = req_ctrl[FIELD_W-1:0];
    assign c_width = req_wide ? DATA_W : NARROW_W;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                          // R8
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);                                        // R8
    AST_ZERO_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_len == '0) |=> (res_data == '0));                 // R3
    AST_START_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(c_start) >= c_width) |=> (res_data == '0));    // R4
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wide) |=> (res_data[DATA_W-1:NARROW_W] == '0)); // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_zero == (res_data == '0)));                    // R7
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !res_carry);                                         // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_data) && $stable(res_zero)));          // R9

endmodule

bind field_extract_unit fx_checker #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .FIELD_W  (FIELD_W),
    .CTRL_W   (CTRL_W)
) u_fx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ctrl  (req_ctrl),
    .req_wide  (req_wide),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_zero  (res_zero),
    .res_carry (res_carry)
);

// File: tb/test_field_extract_unit.sv
`timescale 1ns/1ps
module test_field_extract_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_src;
    logic [15:0] req_ctrl;
    logic        req_wide;
    logic        res_valid;
    logic [63:0] res_data;
    logic        res_zero;
    logic        res_carry;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    field_extract_unit i_field_extract_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_ctrl  (req_ctrl),
        .req_wide  (req_wide),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_zero  (res_zero),
        .res_carry (res_carry)
    );

    localparam int N_VEC = 12;
    localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] O = 64'hFFFF_FFFF_FFFF_FFFF;

    // Table rows: source, control {len,start}, wide, expected result
    localparam logic [63:0] T_SRC [N_VEC] = '{
        A, A, A, A, A, A, A, O, O, A, 64'hFFFF_FFFF_0000_0000, A};
    localparam logic [15:0] T_CTRL [N_VEC] = '{
        16'h0804,  // R2 len 8 start 4
        16'h1020,  // R1 len 16 start 32
        16'h1018,  // R5 narrow over-run
        16'h0820,  // R4 narrow start 32
        16'h0000,  // R3 zero length
        16'hFF00,  // R5 length 255 from 0
        16'h4038,  // R5 wide over-run from 56
        16'hFF00,  // R6 narrow, all ones
        16'h013F,  // R2 top bit only
        16'hFFFF,  // R4 start 255
        16'h2000,  // R6 upper source ignored
        16'h0C08}; // R2 len 12 start 8
    localparam logic T_WIDE [N_VEC] = '{
        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] T_EXP [N_VEC] = '{
        64'hDE, 64'h4567, 64'h89, 64'h0, 64'h0, A, 64'h01,
        64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h0, 64'hBCD};

    function automatic logic [63:0] ref_extract(input logic [63:0] src,
                                                input logic [15:0] ctrl,
                                                input logic wide);
        logic [63:0] op;
        logic [63:0] r;
        int w;
        int s;
        int l;
        w  = wide ? 64 : 32;
        op = wide ? src : {32'h0, src[31:0]};
        s  = int'(ctrl[7:0]);
        l  = int'(ctrl[15:8]);
        r  = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < l && (s + i) < w) r[i] = op[s + i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [63:0] s, input logic [15:0] c, input logic w);
        req_valid = v;
        req_src   = s;
        req_ctrl  = c;
        req_wide  = w;
    endtask

    // Checks a result that was requested one clock earlier
    task automatic chk_result(input string req, input logic [63:0] exp);
        chk({req, " data"}, res_data, exp);
        chk({req, " zero flag R7"}, {63'h0, res_zero}, {63'h0, exp == 64'h0});
        chk({req, " carry R7"}, {63'h0, res_carry}, 64'h0);
        chk({req, " valid R8"}, {63'h0, res_valid}, 64'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, '0, '0, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 res_valid", {63'h0, res_valid}, 64'h0);
        chk("R10 res_data", res_data, 64'h0);
        chk("R10 res_zero", {63'h0, res_zero}, 64'h1);
        chk("R10 res_carry", {63'h0, res_carry}, 64'h0);

        // Table walk, back-to-back requests (R1 R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < N_VEC; i++) begin
            drive(1'b1, T_SRC[i], T_CTRL[i], T_WIDE[i]);
            @(negedge clk);
            chk_result($sformatf("table vector %0d", i), T_EXP[i]);
        end

        // R9: idle cycles with changing inputs leave the outputs alone
        drive(1'b0, O, 16'h4000, 1'b1);
        @(negedge clk);
        chk("R8 valid drops when idle", {63'h0, res_valid}, 64'h0);
        chk("R9 data held", res_data, 64'hBCD);
        drive(1'b0, 64'h0, 16'h0000, 1'b0);
        @(negedge clk);
        chk("R9 data held second idle", res_data, 64'hBCD);
        chk("R9 zero flag held", {63'h0, res_zero}, 64'h0);

        // R3 zero length with non-zero start
        drive(1'b1, O, 16'h0005, 1'b1);
        @(negedge clk);
        chk_result("R3 length 0 start 5", 64'h0);

        // R4 boundaries: start 64 wide, start 31 narrow in range
        drive(1'b1, O, 16'h0840, 1'b1);
        @(negedge clk);
        chk_result("R4 wide start 64", 64'h0);
        drive(1'b1, O, 16'h081F, 1'b0);
        @(negedge clk);
        chk_result("R4 narrow start 31", 64'h1);
        drive(1'b1, O, 16'h083F, 1'b1);
        @(negedge clk);
        chk_result("R4 wide start 63", 64'h1);

        // R5 length exactly the width, and over-run in narrow mode
        drive(1'b1, A, 16'h4000, 1'b1);
        @(negedge clk);
        chk_result("R5 length 64", A);
        drive(1'b1, O, 16'hFF1C, 1'b0);
        @(negedge clk);
        chk_result("R5 narrow over-run from 28", 64'hF);

        // R6 narrow mode field in the middle
        drive(1'b1, O, 16'h0810, 1'b0);
        @(negedge clk);
        chk_result("R6 narrow len 8 start 16", 64'hFF);

        // R1 R2 random controls against the behavioural reference
        for (int n = 0; n < 300; n++) begin
            logic [63:0] s;
            logic [15:0] c;
            logic        w;
            s = {$urandom, $urandom};
            if (n % 4 == 0) c = 16'($urandom);
            else c = {8'($urandom % 72), 8'($urandom % 72)};
            w = 1'($urandom);
            drive(1'b1, s, c, w);
            @(negedge clk);
            chk_result($sformatf("R1 R2 random %0d ctrl=%h wide=%0b", n, c, w),
                       ref_extract(s, c, w));
        end

        drive(1'b0, '0, '0, 1'b1);
        @(negedge clk);
        chk("R8 valid low at end", {63'h0, res_valid}, 64'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule